// File: doc/BRIEF.md
# Bit-Serial Shift-Add Multiplier

This block multiplies two unsigned `N`-bit operands with a single full adder. The multiplicand and multiplier are captured into internal registers on a start strobe. The block then runs `N` outer passes, one for each multiplier bit, starting from the least significant bit.

Each pass has two parts:

- **Accumulation.** For `N` cycles, the adder combines one bit of the partial product with the matching bit of the running high half. A carry flip-flop holds the carry between bits. The sum re-enters the high half at its most significant end, while the multiplicand rotates to line up the next bit.
- **Carry insertion.** One closing cycle pushes the stored carry into the high half and clears the flip-flop. The same cycle moves the lowest bit of the high half into the low half as a finished product bit, and advances the multiplier.

A multiplication therefore takes `N*(N+1)` cycles. After the last cycle, the `2N`-bit product `{high, low}` stays on the output until the next start. The block suits area-limited paths where a full array multiplier would be too large and the latency is acceptable.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` pulse while `busy` is 0 captures `a_in` and `b_in`. On the following cycle, `busy` is 1 and `product` reads all zeros.
- R3: When `done` is 1, `product` equals the unsigned product `a_in*b_in` of the captured operands (for example, with N=4, 1011 times 0101 gives 00110111).
- R4: `done` rises exactly `N*(N+1)` clock edges after the edge that accepted `start`. `busy` stays 1 throughout that interval.
- R5: `done` is a single-cycle pulse, and `busy` is 0 whenever `done` is 1.
- R6: A `start` pulse while `busy` is 1 is ignored. Neither the result nor the completion time of the running multiplication changes.
- R7: While `busy` is 0 and no `start` is given, `product` holds its value.
- R8: The carry flip-flop is zero on the cycle after every carry-insertion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| a_in | input | N | Multiplicand |
| b_in | input | N | Multiplier |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Unsigned product, high half above low half |

## Verification
A carry that is lost or left over in the flip-flop shows up as a wrong high half, and sometimes as a wrong low bit. The error appears in `product` on the `done` cycle of the same multiplication. A miscounted pass or accumulation cycle moves `done` away from the `N*(N+1)` cycle mark. It also misaligns the bits that move into the low half. The exhaustive 4-bit sweep and the random 8-bit run catch both kinds of fault within one operation. The check on the cycle after `done` exposes any register that keeps shifting after completion.

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  a_q, b_q, hi_q, lo_q;
  logic          carry_q, busy_q, done_q;
  logic [CW-1:0] bit_cnt, pass_cnt;

  logic closing, pp, sum, cout, hi_msb;
  logic shift_a, shift_b, shift_hi, shift_lo, sel_sum, clr_carry;

  assign closing   = (bit_cnt == CW'(N));
  assign shift_a   = busy_q & ~closing;
  assign shift_b   = busy_q & closing;
  assign shift_hi  = busy_q;
  assign shift_lo  = busy_q & closing;
  assign sel_sum   = ~closing;
  assign clr_carry = closing;

  assign pp     = a_q[0] & b_q[0];
  assign sum    = pp ^ hi_q[0] ^ carry_q;
  assign cout   = (pp & hi_q[0]) | (pp & carry_q) | (hi_q[0] & carry_q);
  assign hi_msb = sel_sum ? sum : carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      carry_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_cnt  <= '0;
      pass_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        a_q      <= a_in;
        b_q      <= b_in;
        hi_q     <= '0;
        lo_q     <= '0;
        carry_q  <= 1'b0;
        busy_q   <= 1'b1;
        bit_cnt  <= '0;
        pass_cnt <= '0;
      end else if (busy_q) begin
        if (shift_a)  a_q  <= {a_q[0], a_q[N-1:1]};
        if (shift_b)  b_q  <= {1'b0, b_q[N-1:1]};
        if (shift_hi) hi_q <= {hi_msb, hi_q[N-1:1]};
        if (shift_lo) lo_q <= {hi_q[0], lo_q[N-1:1]};
        carry_q <= clr_carry ? 1'b0 : cout;
        if (closing) begin
          bit_cnt  <= '0;
          pass_cnt <= pass_cnt + 1'b1;
          if (pass_cnt == CW'(N - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = {hi_q, lo_q};
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product,
  input logic           closing,
  input logic           carry_q
);
  int unsigned run_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cycles <= 0;
    else if (start && !busy) run_cycles <= 0;
    else if (busy) run_cycles <= run_cycles + 1;
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product == '0));  // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cycles == N * (N + 1)));  // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));  // R7
  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && closing) |=> !carry_q);  // R8
endmodule

bind shift_add_mul shift_add_mul_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .product(product), .closing(closing), .carry_q(carry_q)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       st4 = 1'b0, st8 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       busy4, done4, busy8, done8;
  logic [7:0]  p4;
  logic [15:0] p8;

  int checks = 0;
  int fails  = 0;

  shift_add_mul #(.N(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(st4), .a_in(a4), .b_in(b4),
    .busy(busy4), .done(done4), .product(p4));

  shift_add_mul #(.N(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .start(st8), .a_in(a8), .b_in(b8),
    .busy(busy8), .done(done8), .product(p8));

  function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b);
    return 8'(a) * 8'(b);
  endfunction

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
    return 16'(a) * 16'(b);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mul4(input logic [3:0] a, input logic [3:0] b, input bit poke);
    int k;
    logic [7:0] held;
    @(negedge clk); a4 = a; b4 = b; st4 = 1'b1;
    @(negedge clk); st4 = 1'b0;
    check(busy4 == 1'b1 && p4 == 8'h00, "R2", {busy4, p4}, 9'h100);
    k = 0;
    while (!done4 && k < 1000) begin
      @(negedge clk);
      k++;
      if (!done4) check(busy4 == 1'b1, "R4", busy4, 1);
      if (poke && k == 3) begin st4 = 1'b1; a4 = ~a; b4 = ~b; end
      else st4 = 1'b0;
    end
    st4 = 1'b0;
    check(k == 20, poke ? "R6" : "R4", k, 20);
    check(p4 == ref4(a, b), poke ? "R6" : "R3", p4, ref4(a, b));
    check(busy4 == 1'b0, "R5", busy4, 0);
    held = p4;
    @(negedge clk);
    check(done4 == 1'b0, "R5", done4, 0);
    check(p4 == held, "R7", p4, held);
  endtask

  task automatic mul8(input logic [7:0] a, input logic [7:0] b, input bit poke);
    int k;
    @(negedge clk); a8 = a; b8 = b; st8 = 1'b1;
    @(negedge clk); st8 = 1'b0;
    check(busy8 == 1'b1 && p8 == 16'h0, "R2", {busy8, p8}, 17'h10000);
    k = 0;
    while (!done8 && k < 1000) begin
      @(negedge clk);
      k++;
      if (poke && k == 10) begin st8 = 1'b1; a8 = ~a; b8 = 8'h5a; end
      else st8 = 1'b0;
    end
    st8 = 1'b0;
    check(k == 72, poke ? "R6" : "R4", k, 72);
    check(p8 == ref8(a, b), poke ? "R6" : "R3", p8, ref8(a, b));
    @(negedge clk);
    check(done8 == 1'b0, "R5", done8, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(busy4 == 0 && done4 == 0 && p4 == 0, "R1", {busy4, done4, p4}, 0);
    check(busy8 == 0 && done8 == 0 && p8 == 0, "R1", {busy8, done8, p8}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy4 == 0 && p4 == 0, "R1", {busy4, p4}, 0);

    mul4(4'b1011, 4'b0101, 1'b0);
    check(p4 == 8'b00110111, "R3", p4, 8'b00110111);
    mul4(4'hf, 4'hf, 1'b1);
    mul4(4'h0, 4'h9, 1'b1);

    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        mul4(4'(i), 4'(j), 1'b0);

    repeat (5) @(negedge clk);
    check(p4 == ref4(4'hf, 4'hf), "R7", p4, ref4(4'hf, 4'hf));

    mul8(8'hff, 8'hff, 1'b0);
    mul8(8'h80, 8'h01, 1'b1);
    mul8(8'h00, 8'hff, 1'b0);
    mul8(8'h01, 8'h80, 1'b0);
    for (int t = 0; t < 60; t++)
      mul8(8'($urandom), 8'($urandom), (t % 7) == 0);

    finish_run();
  end
endmodule